// File: doc/BRIEF.md
# Four-Axis Counter Host Register Interface

This block sits between an 8-bit asynchronous host bus and the register banks of a four-axis counter peripheral. The host drives an active-low chip select, an active-low read strobe, an active-low write strobe, a 2-bit axis number and a 3-bit register number. All of these, and the incoming data byte, pass through two-flop synchronizers into the system clock. A write commits once, at the trailing (rising) edge of the write strobe, using the address and data held at that moment. A read drives the selected byte onto the data bus while the read is active.

Each axis owns a private register set: two mode bytes, a three-byte preset, a 4-bit interrupt mask and a write-only command port. The same register number has different meanings for reads and writes. Reads select the packed interrupt status and mask byte, the two mode bytes, an externally supplied status byte, or one of three externally supplied output-latch bytes. Writes select the mask, the mode bytes, the preset bytes or the command port. A command write does not store the byte. It produces a one-clock pulse for that axis toward the counter core and presents the byte beside the pulse. The pad-level bus is split into an input byte, an output byte and an output enable. The output enable low stands for the high-impedance state.

Top module: `axis_hostbus_if`

## Requirements
- R1: `db_oe` is low whenever the synchronized chip select is high, whatever the two strobes are doing.
- R2: With chip select low and the read and write strobes both low, or both high, no register changes and `db_oe` stays low. A write strobe that rises while the read strobe is low commits nothing.
- R3: Read map by register number: 0 packed interrupt byte, 1 mode byte 0, 2 mode byte 1, 3 status input byte, 4/5/6 latch bytes 0/1/2 (byte k = bits 8k+7:8k of the axis's 24-bit latch input). Register number 7 leaves `db_oe` low.
- R4: Write map by register number: 0 interrupt mask (data bits 3:0), 1 mode byte 0, 2 mode byte 1, 4/5/6 preset bytes 0/1/2 (byte k = preset bits 8k+7:8k), 7 command. A write to register number 3 changes nothing.
- R5: A read of register number 0 returns the axis's interrupt mask in bits 3:0 and its 4-bit interrupt status input in bits 7:4.
- R6: The axis number n (0 to 3) selects register set n. Axis n owns bits 8n+7:8n of `mode0_o`, `mode1_o` and `status_i`, bits 4n+3:4n of `irq_mask_o` and `irq_stat_i`, bits 24n+23:24n of `preset_o` and `latch_i`, and bit n of `cmd_pulse_o`. A write touches no other axis.
- R7: A write takes effect only after the rising edge of the write strobe. It uses the data and address present at that edge, not values driven earlier in the same pulse.
- R8: `db_oe` is high, with the selected byte on `db_o`, only while chip select and the read strobe are low and the write strobe is high.
- R9: A command write gives exactly one one-clock pulse on that axis's `cmd_pulse_o` bit, with the written byte on `cmd_byte_o` in the same cycle. No readable register changes.
- R10: Reset clears every mode, preset and mask register to zero and holds `db_oe` and `cmd_pulse_o` low.
- R11: Each write strobe pulse commits at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low, commits on rising edge |
| axis_sel | input | 2 | Axis number |
| reg_sel | input | 3 | Register number |
| db_i | input | 8 | Data byte from the host |
| db_o | output | 8 | Read data byte to the host |
| db_oe | output | 1 | Drive enable for the data pads (low = high impedance) |
| irq_stat_i | input | 16 | Interrupt status, 4 bits per axis |
| status_i | input | 32 | Status byte per axis |
| latch_i | input | 96 | Output latch, 24 bits per axis |
| mode0_o | output | 32 | Mode byte 0 per axis |
| mode1_o | output | 32 | Mode byte 1 per axis |
| preset_o | output | 96 | Preset, 24 bits per axis |
| irq_mask_o | output | 16 | Interrupt mask, 4 bits per axis |
| cmd_pulse_o | output | 4 | One-clock command pulse per axis |
| cmd_byte_o | output | 8 | Byte of the most recent command write |

## Verification
A misdecoded write address or axis shows up as a wrong byte on a register output port within three clocks of the write strobe's rising edge. On the next readback of the full map it also shows as a wrong `db_o` value. A bad edge detector shows up as a count of command pulses other than one per command write, or as a register that changes while the strobe is still low. A faulty read qualifier shows up as `db_oe` high during a strobe conflict, with chip select high, or at register number 7, about three clocks after the offending bus state is applied.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int BYTE_W    = 8;
  localparam int NIB_W     = 4;
  localparam int REG_SEL_W = 3;
  localparam int PRE_BYTES = 3;
  localparam int PRE_W     = PRE_BYTES * BYTE_W;

  typedef enum logic [REG_SEL_W-1:0] {
    RD_IRQ   = 3'd0,
    RD_MODE0 = 3'd1,
    RD_MODE1 = 3'd2,
    RD_STAT  = 3'd3,
    RD_LAT0  = 3'd4,
    RD_LAT1  = 3'd5,
    RD_LAT2  = 3'd6,
    RD_NONE  = 3'd7
  } rd_sel_e;

  typedef enum logic [REG_SEL_W-1:0] {
    WR_MASK  = 3'd0,
    WR_MODE0 = 3'd1,
    WR_MODE1 = 3'd2,
    WR_NONE  = 3'd3,
    WR_PRE0  = 3'd4,
    WR_PRE1  = 3'd5,
    WR_PRE2  = 3'd6,
    WR_CMD   = 3'd7
  } wr_sel_e;

  // Packed interrupt byte: status nibble high, mask nibble low.
  function automatic logic [BYTE_W-1:0] pack_irq(input logic [NIB_W-1:0] mask,
                                                 input logic [NIB_W-1:0] stat);
    return {stat, mask};
  endfunction

  // Byte k of a multi-byte word, little-endian.
  function automatic logic [BYTE_W-1:0] byte_of(input logic [PRE_W-1:0] word,
                                                input int unsigned k);
    return word[k*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hb_strobe.sv
module hb_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic s_cs_n,
  input  logic s_rd_n,
  input  logic s_wr_n,
  output logic wr_en,
  output logic rd_active
);
  logic wr_low_q;
  logic rd_low_q;
  logic wr_rise;
  logic rd_quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_low_q <= 1'b0;
      rd_low_q <= 1'b0;
    end else begin
      wr_low_q <= ~s_wr_n;
      rd_low_q <= ~s_rd_n;
    end
  end

  assign wr_rise   = wr_low_q & s_wr_n;
  assign rd_quiet  = s_rd_n & ~rd_low_q;
  assign wr_en     = wr_rise & ~s_cs_n & rd_quiet;
  assign rd_active = ~s_cs_n & ~s_rd_n & s_wr_n;

  // R11: one commit per strobe pulse
  a_r11_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R7: a commit needs the strobe to have been low one sample earlier
  a_r7_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(!s_wr_n));
  // R2: no commit while a read strobe was seen low on the previous sample
  a_r2_no_conflict_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!s_rd_n) |-> !wr_en);
endmodule

// File: rtl/hb_axis_bank.sv
module hb_axis_bank
  import hbus_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [REG_SEL_W-1:0] reg_sel,
  input  logic [BYTE_W-1:0]    data,
  output logic [BYTE_W-1:0]    mode0,
  output logic [BYTE_W-1:0]    mode1,
  output logic [PRE_W-1:0]     preset,
  output logic [NIB_W-1:0]     mask,
  output logic                 cmd_pulse
);
  logic hit_mask, hit_m0, hit_m1, hit_cmd;

  assign hit_mask = we && (reg_sel == WR_MASK);
  assign hit_m0   = we && (reg_sel == WR_MODE0);
  assign hit_m1   = we && (reg_sel == WR_MODE1);
  assign hit_cmd  = we && (reg_sel == WR_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode0     <= '0;
      mode1     <= '0;
      mask      <= '0;
      cmd_pulse <= 1'b0;
    end else begin
      if (hit_m0)   mode0 <= data;
      if (hit_m1)   mode1 <= data;
      if (hit_mask) mask  <= data[NIB_W-1:0];
      cmd_pulse <= hit_cmd;
    end
  end

  for (genvar k = 0; k < PRE_BYTES; k++) begin : g_pre
    logic hit_pre;
    assign hit_pre = we && (reg_sel == REG_SEL_W'(int'(WR_PRE0) + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       preset[k*BYTE_W +: BYTE_W] <= '0;
      else if (hit_pre) preset[k*BYTE_W +: BYTE_W] <= data;
    end
  end

  // R9: command pulse lasts one clock
  a_r9_cmd_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse |=> !cmd_pulse);
  // R9: command write leaves stored registers alone
  a_r9_cmd_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && reg_sel == WR_CMD) |=> ($stable(mode0) && $stable(mode1) && $stable(preset) && $stable(mask)));
  // R4: register number 3 is a write no-op
  a_r4_hole_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (we && reg_sel == WR_NONE) |=> ($stable(mode0) && $stable(mode1) && $stable(preset) && $stable(mask) && !cmd_pulse));
  // R11/R4: registers only move on a write enable
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(mode0) && $stable(mode1) && $stable(preset) && $stable(mask)));
endmodule

// File: rtl/hb_read_mux.sv
module hb_read_mux
  import hbus_pkg::*;
#(
  parameter int N_AXES = 4,
  localparam int AXIS_W = (N_AXES > 1) ? $clog2(N_AXES) : 1
) (
  input  logic [AXIS_W-1:0]         axis,
  input  logic [REG_SEL_W-1:0]      reg_sel,
  input  logic [N_AXES*NIB_W-1:0]   mask_i,
  input  logic [N_AXES*NIB_W-1:0]   irq_i,
  input  logic [N_AXES*BYTE_W-1:0]  mode0_i,
  input  logic [N_AXES*BYTE_W-1:0]  mode1_i,
  input  logic [N_AXES*BYTE_W-1:0]  stat_i,
  input  logic [N_AXES*PRE_W-1:0]   latch_i,
  output logic [BYTE_W-1:0]         byte_o,
  output logic                      hit_o
);
  int unsigned ax;
  logic [PRE_W-1:0] lat_word;

  always_comb begin
    ax       = int'(axis);
    lat_word = latch_i[ax*PRE_W +: PRE_W];
    hit_o    = 1'b1;
    byte_o   = '0;
    case (rd_sel_e'(reg_sel))
      RD_IRQ:   byte_o = pack_irq(mask_i[ax*NIB_W +: NIB_W], irq_i[ax*NIB_W +: NIB_W]);
      RD_MODE0: byte_o = mode0_i[ax*BYTE_W +: BYTE_W];
      RD_MODE1: byte_o = mode1_i[ax*BYTE_W +: BYTE_W];
      RD_STAT:  byte_o = stat_i[ax*BYTE_W +: BYTE_W];
      RD_LAT0:  byte_o = byte_of(lat_word, 0);
      RD_LAT1:  byte_o = byte_of(lat_word, 1);
      RD_LAT2:  byte_o = byte_of(lat_word, 2);
      default:  hit_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/axis_hostbus_if.sv
module axis_hostbus_if
  import hbus_pkg::*;
#(
  parameter int N_AXES      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int AXIS_W     = (N_AXES > 1) ? $clog2(N_AXES) : 1,
  localparam int ADDR_W     = AXIS_W + REG_SEL_W + BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      rd_n,
  input  logic                      wr_n,
  input  logic [AXIS_W-1:0]         axis_sel,
  input  logic [REG_SEL_W-1:0]      reg_sel,
  input  logic [BYTE_W-1:0]         db_i,
  output logic [BYTE_W-1:0]         db_o,
  output logic                      db_oe,
  input  logic [N_AXES*NIB_W-1:0]   irq_stat_i,
  input  logic [N_AXES*BYTE_W-1:0]  status_i,
  input  logic [N_AXES*PRE_W-1:0]   latch_i,
  output logic [N_AXES*BYTE_W-1:0]  mode0_o,
  output logic [N_AXES*BYTE_W-1:0]  mode1_o,
  output logic [N_AXES*PRE_W-1:0]   preset_o,
  output logic [N_AXES*NIB_W-1:0]   irq_mask_o,
  output logic [N_AXES-1:0]         cmd_pulse_o,
  output logic [BYTE_W-1:0]         cmd_byte_o
);
  logic                 s_cs_n, s_rd_n, s_wr_n;
  logic [AXIS_W-1:0]    s_axis;
  logic [REG_SEL_W-1:0] s_reg;
  logic [BYTE_W-1:0]    s_data;
  logic                 wr_en, rd_active;
  logic [N_AXES-1:0]    bank_we;
  logic [BYTE_W-1:0]    rd_byte;
  logic                 rd_hit;
  logic                 cmd_wr;

  hb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_strobe (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, rd_n, wr_n}),
    .q({s_cs_n, s_rd_n, s_wr_n})
  );

  hb_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
    .clk(clk), .rst_n(rst_n),
    .d({axis_sel, reg_sel, db_i}),
    .q({s_axis, s_reg, s_data})
  );

  hb_strobe u_strobe (
    .clk(clk), .rst_n(rst_n),
    .s_cs_n(s_cs_n), .s_rd_n(s_rd_n), .s_wr_n(s_wr_n),
    .wr_en(wr_en), .rd_active(rd_active)
  );

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    assign bank_we[a] = wr_en && (s_axis == AXIS_W'(a));
    hb_axis_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .we(bank_we[a]), .reg_sel(s_reg), .data(s_data),
      .mode0(mode0_o[a*BYTE_W +: BYTE_W]),
      .mode1(mode1_o[a*BYTE_W +: BYTE_W]),
      .preset(preset_o[a*PRE_W +: PRE_W]),
      .mask(irq_mask_o[a*NIB_W +: NIB_W]),
      .cmd_pulse(cmd_pulse_o[a])
    );
  end

  hb_read_mux #(.N_AXES(N_AXES)) u_rmux (
    .axis(s_axis), .reg_sel(s_reg),
    .mask_i(irq_mask_o), .irq_i(irq_stat_i),
    .mode0_i(mode0_o), .mode1_i(mode1_o),
    .stat_i(status_i), .latch_i(latch_i),
    .byte_o(rd_byte), .hit_o(rd_hit)
  );

  assign cmd_wr = wr_en && (s_reg == WR_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_oe      <= 1'b0;
      db_o       <= '0;
      cmd_byte_o <= '0;
    end else begin
      db_oe <= rd_active && rd_hit;
      db_o  <= (rd_active && rd_hit) ? rd_byte : '0;
      if (cmd_wr) cmd_byte_o <= s_data;
    end
  end

  // R6: at most one axis bank written per commit
  a_r6_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));
  // R1: chip select high keeps the bus undriven
  a_r1_cs_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs_n |=> !db_oe);
  // R2: both strobes low never drives the bus
  a_r2_both_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_rd_n && !s_wr_n) |=> !db_oe);
  // R3: register number 7 is never driven on a read
  a_r3_hole_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (s_reg == RD_NONE) |=> !db_oe);
  // R9: at most one axis pulses per clock
  a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_pulse_o));
  // R10: leaving reset the bus is undriven
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !db_oe);
endmodule

// File: tb/sim_axis_hostbus_if.sv
`timescale 1ns/1ps
module sim_axis_hostbus_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] axis_sel = '0;
  logic [2:0] reg_sel = '0;
  logic [7:0] db_i = '0;
  logic [15:0] irq_stat_i;
  logic [31:0] status_i;
  logic [95:0] latch_i;
  wire  [7:0]  db_o;
  wire         db_oe;
  wire  [31:0] mode0_o, mode1_o;
  wire  [95:0] preset_o;
  wire  [15:0] irq_mask_o;
  wire  [3:0]  cmd_pulse_o;
  wire  [7:0]  cmd_byte_o;

  always #2 clk = ~clk;

  axis_hostbus_if u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .axis_sel(axis_sel), .reg_sel(reg_sel), .db_i(db_i),
    .db_o(db_o), .db_oe(db_oe),
    .irq_stat_i(irq_stat_i), .status_i(status_i), .latch_i(latch_i),
    .mode0_o(mode0_o), .mode1_o(mode1_o), .preset_o(preset_o),
    .irq_mask_o(irq_mask_o), .cmd_pulse_o(cmd_pulse_o), .cmd_byte_o(cmd_byte_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] m0 [4];
  logic [7:0] m1 [4];
  logic [7:0] pre [4][3];
  logic [3:0] msk [4];
  int         cmd_cnt [4];
  logic [7:0] cmd_last;

  function automatic logic [3:0] irq_val(int a);  return 4'(9 + a * 5); endfunction
  function automatic logic [7:0] stat_val(int a); return 8'(8'hC3 - a * 8'h21); endfunction
  function automatic logic [7:0] lat_val(int a, int b); return 8'(8'h1F * (b + 1) + a * 8'h05); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_write(int a, int r, logic [7:0] v);
    @(negedge clk);
    axis_sel = 2'(a); reg_sel = 3'(r); db_i = v; cs_n = 0;
    ticks(3); wr_n = 0;
    ticks(4); wr_n = 1;
    ticks(5); cs_n = 1;
    ticks(3);
  endtask

  task automatic bus_read(int a, int r, output logic oe, output logic [7:0] d);
    @(negedge clk);
    axis_sel = 2'(a); reg_sel = 3'(r); cs_n = 0; rd_n = 0;
    ticks(5); oe = db_oe; d = db_o;
    rd_n = 1; cs_n = 1;
    ticks(4);
  endtask

  task automatic model_write(int a, int r, logic [7:0] v);
    case (r)
      0: msk[a] = v[3:0];
      1: m0[a] = v;
      2: m1[a] = v;
      4, 5, 6: pre[a][r-4] = v;
      default: ;
    endcase
  endtask

  function automatic logic [7:0] model_read(int a, int r);
    case (r)
      0: return {irq_val(a), msk[a]};
      1: return m0[a];
      2: return m1[a];
      3: return stat_val(a);
      4, 5, 6: return lat_val(a, r - 4);
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge clk) begin
    for (int a = 0; a < 4; a++)
      if (cmd_pulse_o[a] === 1'b1) begin cmd_cnt[a]++; cmd_last = cmd_byte_o; end
  end

  task automatic check_ports(string req);
    for (int a = 0; a < 4; a++) begin
      check(req, mode0_o[a*8 +: 8], m0[a]);
      check(req, mode1_o[a*8 +: 8], m1[a]);
      check(req, irq_mask_o[a*4 +: 4], msk[a]);
      check(req, preset_o[a*24 +: 24], {pre[a][2], pre[a][1], pre[a][0]});
    end
  endtask

  initial begin
    for (int a = 0; a < 4; a++) begin
      irq_stat_i[a*4 +: 4] = irq_val(a);
      status_i[a*8 +: 8]   = stat_val(a);
      for (int b = 0; b < 3; b++) latch_i[a*24 + b*8 +: 8] = lat_val(a, b);
      m0[a] = 0; m1[a] = 0; msk[a] = 0; cmd_cnt[a] = 0;
      for (int b = 0; b < 3; b++) pre[a][b] = 0;
    end
  end

  initial begin : main
    logic oe;
    logic [7:0] d;
    int exp_cnt [4];
    for (int a = 0; a < 4; a++) exp_cnt[a] = 0;
    ticks(4);
    // R10: reset state
    check("R10 oe in reset", db_oe, 0);
    check("R10 pulses in reset", cmd_pulse_o, 0);
    check_ports("R10 regs in reset");
    rst_n = 1;
    ticks(3);
    check("R10 oe after reset", db_oe, 0);

    // R4 R6 R9 R11: full write sweep, two passes with complementary data
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 4; a++)
        for (int r = 0; r < 8; r++) begin
          logic [7:0] v;
          v = 8'(a * 8'h47 + r * 8'h1D + 8'h3C);
          if (p == 1) v = ~v;
          bus_write(a, r, v);
          model_write(a, r, v);
          if (r == 7) begin
            exp_cnt[a]++;
            for (int b = 0; b < 4; b++) check("R9 pulse count", 32'(cmd_cnt[b]), 32'(exp_cnt[b]));
            check("R9 command byte", cmd_last, v);
          end
          check_ports("R4 R6 write map");
        end

    // R3 R5 R6 R8: full read sweep
    for (int a = 0; a < 4; a++)
      for (int r = 0; r < 8; r++) begin
        bus_read(a, r, oe, d);
        if (r == 7) check("R3 addr 7 undriven", oe, 0);
        else begin
          check("R8 oe on read", oe, 1);
          check(r == 0 ? "R5 packed irq" : "R3 read map", d, model_read(a, r));
        end
      end

    // R1: chip select high with read low
    @(negedge clk); axis_sel = 1; reg_sel = 1; cs_n = 1; rd_n = 0;
    ticks(5); check("R1 cs high read", db_oe, 0);
    rd_n = 1; ticks(3);

    // R1 R2: chip select high write pulse commits nothing
    @(negedge clk); db_i = 8'hE7; wr_n = 0; ticks(4); wr_n = 1; ticks(6);
    check_ports("R1 cs high write ignored");

    // R2: both strobes high with cs low
    @(negedge clk); cs_n = 0; ticks(5);
    check("R2 both high no drive", db_oe, 0);
    // R2: both low, then write rises while read is low
    rd_n = 0; wr_n = 0; db_i = 8'h96; ticks(5);
    check("R2 both low no drive", db_oe, 0);
    wr_n = 1; ticks(6);
    check_ports("R2 conflict write ignored");
    rd_n = 1; ticks(4); cs_n = 1; ticks(3);
    check_ports("R2 after conflict");

    // R7: data changed mid-pulse; commit only at the rising edge
    @(negedge clk); axis_sel = 2; reg_sel = 2; db_i = 8'h11; cs_n = 0;
    ticks(3); wr_n = 0; ticks(4);
    db_i = 8'hC8; ticks(4);
    check("R7 no commit while low", mode1_o[16 +: 8], m1[2]);
    wr_n = 1; ticks(5); cs_n = 1; ticks(3);
    m1[2] = 8'hC8;
    check("R7 edge data used", mode1_o[16 +: 8], 8'hC8);
    check_ports("R7 other regs");

    // R9: command write leaves readable registers and R11 single pulse
    bus_write(3, 7, 8'h5E);
    exp_cnt[3]++;
    check("R11 single pulse", 32'(cmd_cnt[3]), 32'(exp_cnt[3]));
    check("R9 cmd byte", cmd_last, 8'h5E);
    check_ports("R9 cmd not stored");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule